// File: doc/BRIEF.md
# Cascaded LED-Driver Serial Loader

This block is the host side of a chain of N daisy-chained 8-channel LED drivers. Each driver has a shift register, a shadow register that takes its value on a strobe edge, and a reset pin. From a fast system clock, the loader produces a slow shift clock, a serial data line and a latch strobe. When a start request is accepted, the whole 8·N-bit word is shifted into the chain and then made visible on all drivers together.

Every timing interval comes from the system clock frequency parameter and the minimum times given in nanoseconds. Each minimum becomes a whole number of cycles, rounded up. The clock low phase may be stretched so that the period minimum and the data-level minimum are both met. Serial data changes only at the middle of the low phase. The loader also keeps the drivers' reset line low from power-up until a release input is seen, so that no output lights spuriously at start-up.

Top module: `led_chain_loader`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `sck`, `lat`, `busy` and `done` are 0 and `drv_rst_n` is 0.
- R2: `drv_rst_n` stays 0 after reset until `drv_release` is sampled high. From then on it stays 1 until the next reset.
- R3: `start` is accepted only while `busy` is 0, and `busy` is 1 in the cycle after acceptance. A `start` raised while `busy` is 1 has no effect on the shifted word or on the clock count.
- R4: One transfer produces exactly 8·N rising edges of `sck`. The value of `sdo` at the k-th rising edge is bit 8·N−k of the word captured at acceptance, so the most significant bit (bit 15 for N=2) goes first and bit 0 goes last.
- R5: Each `sck` high phase lasts at least 380 ns and each low phase inside a transfer lasts at least 380 ns. Rising edges are at least 800 ns apart.
- R6: `sdo` changes only while `sck` is low on both sides of the change. It is stable for at least 150 ns before and at least 150 ns after every rising edge.
- R7: Within a transfer, every level of `sdo` lasts at least 780 ns.
- R8: `lat` rises once per transfer, after the last rising edge, while `sck` is low and at least 200 ns after that edge. It stays high for at least 380 ns.
- R9: `busy` stays 1 from acceptance until `lat` falls. In the cycle `lat` falls, `busy` drops and `done` is 1 for exactly that one cycle.
- R10: While `busy` is 0, `sck` and `lat` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load a new word |
| data_in | input | 8·N_DEV | Word for the chain, bit 8·N−1 for the farthest driver's top channel |
| drv_release | input | 1 | Releases the drivers' reset line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the latch strobe ends |
| sck | output | 1 | Shift clock to the chain |
| sdo | output | 1 | Serial data to the first driver |
| lat | output | 1 | Latch strobe to all drivers |
| drv_rst_n | output | 1 | Active-low reset to all drivers |

## Verification
A wrong shift-register or bit-counter state shows up as a wrong word assembled from `sdo` at the rising edges, or as the wrong number of edges. This is visible by the time `lat` rises, one transfer later at most. A wrong phase counter or phase state shows up at the very next edge of `sck` or `lat`, as a phase that is too short, a data change during the high phase, or a missing or early strobe. A bad handshake state shows up within a cycle as `busy` or `done` disagreeing with the strobe falling.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_HIGH  = 3'd2,
    PH_GAP   = 3'd3,
    PH_LATCH = 3'd4
  } phase_t;

  // smallest cycle count whose duration reaches ns at hz
  function automatic int ns_cycles(input longint ns, input longint hz);
    longint prod;
    prod = ns * hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // high phase: covers the high minimum and the hold after the rise
  function automatic int high_cycles(input int hz, input int hi_ns, input int hold_ns);
    return imax(imax(ns_cycles(hi_ns, hz), ns_cycles(hold_ns, hz)), 1);
  endfunction

  // low phase: stretched for period, data level width and mid-low setup
  function automatic int low_cycles(input int hz, input int lo_ns, input int per_ns,
                                    input int lvl_ns, input int su_ns, input int hi_c);
    int c;
    c = imax(ns_cycles(lo_ns, hz), ns_cycles(per_ns, hz) - hi_c);
    c = imax(c, ns_cycles(lvl_ns, hz) - hi_c);
    c = imax(c, 2 * ns_cycles(su_ns, hz));
    return imax(c, 2);
  endfunction

  // extra low cycles after the last high phase before the strobe
  function automatic int gap_cycles(input int hz, input int gap_ns, input int hi_c);
    return imax(ns_cycles(gap_ns, hz) - hi_c, 1);
  endfunction

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/led_shift_out.sv
module led_shift_out #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              step,
  output logic              sdo
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      sdo  <= 1'b0;
    end else if (load) begin
      sreg <= word;
    end else if (step) begin
      sdo  <= sreg[WORD_W-1];
      sreg <= {sreg[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/led_drv_reset_hold.sv
module led_drv_reset_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic release_req,
  output logic drv_rst_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           drv_rst_n <= 1'b0;
    else if (release_req) drv_rst_n <= 1'b1;
  end
endmodule

// File: rtl/led_chain_loader.sv
module led_chain_loader
  import led_chain_pkg::*;
#(
  parameter int SYS_CLK_HZ    = 50_000_000,
  parameter int N_DEV         = 2,
  parameter int SCK_PERIOD_NS = 800,
  parameter int SCK_HIGH_NS   = 380,
  parameter int SCK_LOW_NS    = 380,
  parameter int SETUP_NS      = 150,
  parameter int HOLD_NS       = 150,
  parameter int LEVEL_NS      = 780,
  parameter int LAT_GAP_NS    = 200,
  parameter int LAT_HIGH_NS   = 380
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [8*N_DEV-1:0]   data_in,
  input  logic                 drv_release,
  output logic                 busy,
  output logic                 done,
  output logic                 sck,
  output logic                 sdo,
  output logic                 lat,
  output logic                 drv_rst_n
);
  localparam int WORD_W = 8 * N_DEV;
  localparam int HI_C   = high_cycles(SYS_CLK_HZ, SCK_HIGH_NS, HOLD_NS);
  localparam int LO_C   = low_cycles(SYS_CLK_HZ, SCK_LOW_NS, SCK_PERIOD_NS,
                                     LEVEL_NS, SETUP_NS, HI_C);
  localparam int MID_C  = LO_C / 2;
  localparam int GAP_C  = gap_cycles(SYS_CLK_HZ, LAT_GAP_NS, HI_C);
  localparam int LAT_C  = imax(ns_cycles(LAT_HIGH_NS, SYS_CLK_HZ), 1);
  localparam int MAX_C  = imax(imax(HI_C, LO_C), imax(GAP_C, LAT_C));
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int BIT_W  = $clog2(WORD_W + 1);

  phase_t             phase, phase_n;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bits_left;
  logic               accept;
  logic               phase_end;
  logic               sdo_update;
  logic               last_bit;

  // named internal events
  assign accept     = (phase == PH_IDLE) && start;
  assign sdo_update = (phase == PH_LOW) && (cnt == CNT_W'(MID_C));
  assign last_bit   = (bits_left == BIT_W'(1));

  always_comb begin
    phase_end = 1'b0;
    unique case (phase)
      PH_LOW:   phase_end = (cnt == CNT_W'(LO_C - 1));
      PH_HIGH:  phase_end = (cnt == CNT_W'(HI_C - 1));
      PH_GAP:   phase_end = (cnt == CNT_W'(GAP_C - 1));
      PH_LATCH: phase_end = (cnt == CNT_W'(LAT_C - 1));
      default:  phase_end = 1'b0;
    endcase
  end

  always_comb begin
    phase_n = phase;
    unique case (phase)
      PH_IDLE:  if (accept)    phase_n = PH_LOW;
      PH_LOW:   if (phase_end) phase_n = PH_HIGH;
      PH_HIGH:  if (phase_end) phase_n = last_bit ? PH_GAP : PH_LOW;
      PH_GAP:   if (phase_end) phase_n = PH_LATCH;
      PH_LATCH: if (phase_end) phase_n = PH_IDLE;
      default:                 phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bits_left <= '0;
      sck       <= 1'b0;
      lat       <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      phase <= phase_n;
      if (accept)
        bits_left <= BIT_W'(WORD_W);
      else if ((phase == PH_HIGH) && phase_end)
        bits_left <= bits_left - 1'b1;
      sck  <= (phase_n == PH_HIGH);
      lat  <= (phase_n == PH_LATCH);
      busy <= (phase_n != PH_IDLE);
      done <= (phase == PH_LATCH) && phase_end;
    end
  end

  led_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((phase == PH_IDLE) || phase_end),
    .cnt   (cnt)
  );

  led_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .word  (data_in),
    .step  (sdo_update),
    .sdo   (sdo)
  );

  led_drv_reset_hold u_rsthold (
    .clk         (clk),
    .rst_n       (rst_n),
    .release_req (drv_release),
    .drv_rst_n   (drv_rst_n)
  );
endmodule

// File: rtl/led_chain_checker.sv
module led_chain_checker #(
  parameter int HI_MIN  = 19,
  parameter int LAT_MIN = 19
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sck,
  input logic sdo,
  input logic lat,
  input logic drv_release,
  input logic drv_rst_n,
  input logic sdo_update
);
  logic [15:0] hi_run, lat_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      lat_run <= '0;
    end else begin
      hi_run  <= sck ? hi_run + 1'b1 : '0;
      lat_run <= lat ? lat_run + 1'b1 : '0;
    end
  end

  assert_drv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_rst_n && !drv_release) |=> !drv_rst_n);
  assert_drv_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_rst_n |=> drv_rst_n);
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_sck_high_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_run >= 16'(HI_MIN)));
  assert_sdo_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> (!sck && !$past(sck)));
  assert_update_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_update |=> !sck);
  assert_lat_no_sck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat |-> !sck);
  assert_lat_high_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat) |-> (lat_run >= 16'(LAT_MIN)));
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !lat));
endmodule

bind led_chain_loader led_chain_checker #(.HI_MIN(HI_C), .LAT_MIN(LAT_C)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .sck         (sck),
  .sdo         (sdo),
  .lat         (lat),
  .drv_release (drv_release),
  .drv_rst_n   (drv_rst_n),
  .sdo_update  (sdo_update)
);

// File: tb/led_chain_loader_test.sv
module led_chain_loader_test;
  localparam int CLK_NS = 20;
  localparam int NDEV   = 2;
  localparam int W      = 8 * NDEV;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, drv_release = 1'b0;
  logic [W-1:0] data_in = '0;
  logic busy, done, sck, sdo, lat, drv_rst_n;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  led_chain_loader #(.SYS_CLK_HZ(50_000_000), .N_DEV(NDEV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .drv_release(drv_release), .busy(busy), .done(done), .sck(sck),
    .sdo(sdo), .lat(lat), .drv_rst_n(drv_rst_n)
  );

  // minimum sample count covering ns at the bench clock
  function automatic int samples(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one transfer; stray>0 raises a second start that many samples in
  task automatic run_xfer(input logic [W-1:0] w, input int stray);
    logic [W-1:0] got = '0;
    int rises = 0, cyc = 0, hi_run = 0, lo_run = 0, lat_run = 0;
    int since_sdo = 0, since_rise = 9999, since_prev_rise = 9999;
    bit changed = 0, lat_seen = 0;
    logic psck = 1'b0, psdo, plat = 1'b0;
    @(negedge clk); start = 1'b1; data_in = w;
    @(negedge clk); start = 1'b0; data_in = ~w;
    check(busy === 1'b1, "R3 busy after accept", busy, 1);
    psdo = sdo;
    forever begin
      if (cyc == stray) start = 1'b1;
      if (cyc == stray + 1) start = 1'b0;
      @(negedge clk); cyc++;
      since_sdo++; since_rise++; since_prev_rise++;
      if (sdo !== psdo) begin
        check(!sck && !psck, "R6 change only while low", sck, 0);
        check(since_rise >= samples(150), "R6 hold after rise", since_rise, samples(150));
        if (changed) check(since_sdo >= samples(780), "R7 level width", since_sdo, samples(780));
        changed = 1; since_sdo = 0;
      end
      if (sck && !psck) begin
        check(since_sdo >= samples(150), "R6 setup before rise", since_sdo, samples(150));
        check(lo_run >= samples(380), "R5 low phase", lo_run, samples(380));
        if (rises > 0) check(since_prev_rise >= samples(800), "R5 period", since_prev_rise, samples(800));
        got = {got[W-2:0], sdo}; rises++;
        since_rise = 0; since_prev_rise = 0;
      end
      if (!sck && psck) check(hi_run >= samples(380), "R5 high phase", hi_run, samples(380));
      if (lat && !plat) begin
        check(!lat_seen && rises == W, "R8 strobe after all clocks", rises, W);
        check(since_rise >= samples(200) && !sck, "R8 strobe gap", since_rise, samples(200));
        lat_seen = 1;
      end
      if (!lat && plat) begin
        check(lat_run >= samples(380), "R8 strobe width", lat_run, samples(380));
        check(done === 1'b1 && busy === 1'b0, "R9 done as strobe ends", {done, busy}, 2);
        break;
      end
      if (busy !== 1'b1) check(0, "R9 busy during transfer", busy, 1);
      hi_run = sck ? hi_run + 1 : 0;
      lo_run = sck ? 0 : lo_run + 1;
      lat_run = lat ? lat_run + 1 : 0;
      psck = sck; psdo = sdo; plat = lat;
      if (cyc > 5000) begin check(0, "R9 transfer hang", cyc, 0); break; end
    end
    check(got === w, "R4 word order", got, w);
    check(rises == W, "R4 edge count", rises, W);
    if (stray > 0) check(got === w, "R3 start while busy ignored", got, w);
    @(negedge clk);
    check(done === 1'b0, "R9 done single cycle", done, 0);
    check(!sck && !lat && !busy, "R10 idle quiet", {sck, lat, busy}, 0);
  endtask

  initial begin
    #(200_000 * CLK_NS);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check({sck, lat, busy, done, drv_rst_n} === 5'b0, "R1 during reset",
          {sck, lat, busy, done, drv_rst_n}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({sck, lat, busy, done, drv_rst_n} === 5'b0, "R1 after reset",
          {sck, lat, busy, done, drv_rst_n}, 0);
    repeat (20) @(negedge clk);
    check(!sck && !lat, "R10 idle after reset", {sck, lat}, 0);
    run_xfer(16'h8001, 0);
    check(drv_rst_n === 1'b0, "R2 held without release", drv_rst_n, 0);
    drv_release = 1'b1; @(negedge clk); drv_release = 1'b0;
    check(drv_rst_n === 1'b1, "R2 released", drv_rst_n, 1);
    run_xfer(16'h0000, 0);
    run_xfer(16'hFFFF, 0);
    run_xfer(16'h5555, 0);
    run_xfer(16'hAAAA, 100);
    for (int i = 0; i < 20; i++) begin
      run_xfer(W'($urandom), (i % 3 == 0) ? int'($urandom_range(1, 600)) : 0);
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    check(drv_rst_n === 1'b1, "R2 stays released", drv_rst_n, 1);
    rst_n = 1'b0; @(negedge clk);
    check(drv_rst_n === 1'b0 && busy === 1'b0, "R1 second reset", {drv_rst_n, busy}, 0);
    rst_n = 1'b1; @(negedge clk);
    finish_run();
  end
endmodule